// File: doc/BRIEF.md
# Three-Wire Serial Control Slave

This block is the control port of a stereo tone and volume processor. A host talks to it over three wires: a bit clock, an identity line and an open-drain data line. Every transfer has two phases. While identity is low the host clocks in an 8-bit byte. The top five bits of that byte select the device and the low three bits pick one of eight functions. After identity returns high, the host clocks in an 8-bit value. The value takes effect only later, when the host sends a separate low pulse on identity with no clock edges in it. Until then, every active setting keeps its old value.

The bus pins run far slower than the system clock. They pass through two-flop synchronisers, and their edges are detected in the system clock domain. If a phase carries more than eight bits, only the last eight are kept. The commit pulse counts only if it lasts at least `MIN_ID_LOW` system cycles. The read function samples two active-low status pins when its address is decoded. It returns them during the last two slots of the value phase by pulling the data line low.

The outputs are the decoded settings: source select and mute, loudness, bass and treble steps, left and right attenuation steps, and channel mode.

Top module: `serialCtrlSlave`

## Requirements
- R1: After reset: `muteOn`=1, `srcSel`=0, `loudOn`=0, `bassStep`=`trebleStep`=6 (flat), `leftAtten`=`rightAtten`=40 (maximum cut), `chanMode`=0 (stereo).
- R2: The address is the last 8 bits shifted in on rising bus-clock edges while identity is low. Only addresses 0x40 to 0x47 select the device, with bits [2:0] choosing the function: 0 source, 1 loudness, 2 bass, 3 treble, 4 left volume, 5 right volume, 6 mode, 7 read. Any other address, or an address phase of fewer than 8 bits, makes the following commit change nothing.
- R3: The value is the last 8 bits shifted in while identity is high after the address phase. A value phase of fewer than 8 bits is never committed.
- R4: The value is written only when identity then goes low for at least `MIN_ID_LOW` system cycles with no rising bus-clock edge, and then returns high. A shorter pulse changes nothing and leaves the pending write in place for a later valid pulse.
- R5: Source function: value[1:0] of 0, 1 or 2 sets `srcSel` to that value and clears `muteOn`. A value of 3 sets `muteOn` and drives `srcSel`=0. Loudness function: `loudOn` = value[0].
- R6: Bass and treble take value[3:0] as a 2 dB step code: 0 is -12 dB and 6 is flat. Codes 12 to 15 all give a step of 12 (+12 dB).
- R7: Each volume channel takes value[5:0] as a 2 dB attenuation step: 0 is 0 dB and 20 is -40 dB. Codes 40 to 63 all give a step of 40 (-80 dB).
- R8: Mode takes value[2:0]. 100 sets `chanMode`=1 (left mono), 101 sets 0 (stereo), and 11x sets 2 (right mono). Any code with bit 2 clear leaves the mode unchanged.
- R9: For read (0x47), both status pins are sampled when the address is decoded. During the value phase, before the 7th rising bus-clock edge, `busDataPullDown` is 1 when status pin [1] was low. Before the 8th edge it is 1 when pin [0] was low. At every other time it is 0, and a later change on the pins does not alter the bits returned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busClk | input | 1 | Serial bit clock from the host, idle high |
| busId | input | 1 | Identity line from the host, idle high |
| busDataIn | input | 1 | Level on the shared data line |
| statusInN | input | 2 | Active-low status pins returned by the read function |
| busDataPullDown | output | 1 | 1 pulls the shared data line low |
| srcSel | output | 2 | Selected stereo source, 0 to 2 |
| muteOn | output | 1 | Mute active |
| loudOn | output | 1 | Loudness compensation on |
| bassStep | output | 4 | Bass step, 0 to 12, 6 flat |
| trebleStep | output | 4 | Treble step, 0 to 12, 6 flat |
| leftAtten | output | 6 | Left attenuation step, 0 to 40 |
| rightAtten | output | 6 | Right attenuation step, 0 to 40 |
| chanMode | output | 2 | 0 stereo, 1 left mono, 2 right mono |

## Verification
The bench targets corner cases that a plausible bug would get wrong:
- Bursts longer than eight bits: a design that kept the first eight bits instead of the last would write the wrong function or value.
- Short phases: a design that committed them would write garbage.
- Commit pulses of exactly `MIN_ID_LOW-1` and `MIN_ID_LOW` cycles: an off-by-one would commit early or never.
- Saturating codes for tone and volume, and mode codes with bit 2 clear: a missed clamp would show out-of-range steps, and a missed hold would corrupt the mode.
- Read transfers whose status pins change mid-phase: a design that sampled late, or used the wrong slot, would return flipped or shifted bits on the data line.

// File: rtl/serctl_pkg.sv
package serctl_pkg;

  localparam int BYTE_W = 8;
  localparam logic [4:0] DEV_BASE = 5'b01000;

  localparam logic [2:0] FN_SOURCE = 3'd0;
  localparam logic [2:0] FN_LOUD   = 3'd1;
  localparam logic [2:0] FN_BASS   = 3'd2;
  localparam logic [2:0] FN_TREBLE = 3'd3;
  localparam logic [2:0] FN_LEFT   = 3'd4;
  localparam logic [2:0] FN_RIGHT  = 3'd5;
  localparam logic [2:0] FN_MODE   = 3'd6;
  localparam logic [2:0] FN_READ   = 3'd7;

  typedef enum logic [1:0] {
    MODE_STEREO = 2'd0,
    MODE_LEFT   = 2'd1,
    MODE_RIGHT  = 2'd2
  } chanMode_e;

  // strobes from control to datapath, all single-cycle unless noted
  typedef struct packed {
    logic sampleBit;   // synchronised data level
    logic shiftAddr;   // rising bus clock, identity low
    logic shiftVal;    // rising bus clock, identity high
    logic decodeAddr;  // identity rose after an address phase
    logic addrFull;    // address phase carried at least 8 bits
    logic commit;      // qualified commit pulse with a full value
    logic slotD1;      // level: before 7th value edge
    logic slotD0;      // level: before 8th value edge
  } busStrobes_t;

endpackage

// File: rtl/serctlControl.sv
module serctlControl
  import serctl_pkg::*;
#(
  parameter int MIN_ID_LOW  = 375,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        busClk,
  input  logic        busId,
  input  logic        busDataIn,
  output busStrobes_t st
);

  localparam int LOW_W = $clog2(MIN_ID_LOW + 1);
  localparam logic [LOW_W-1:0] LOW_MAX = LOW_W'(MIN_ID_LOW);
  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_W);

  logic [2:0] busRaw;
  logic [SYNC_STAGES-1:0] syncChain [3];
  assign busRaw = {busDataIn, busId, busClk};

  for (genvar i = 0; i < 3; i++) begin : g_sync
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) syncChain[i] <= '1;
      else       syncChain[i] <= {syncChain[i][SYNC_STAGES-2:0], busRaw[i]};
    end
  end

  logic clkS, idS, dataS, clkPrev, idPrev;
  assign clkS  = syncChain[0][SYNC_STAGES-1];
  assign idS   = syncChain[1][SYNC_STAGES-1];
  assign dataS = syncChain[2][SYNC_STAGES-1];

  logic clkRise, idRise, idFall;
  assign clkRise = clkS & ~clkPrev;
  assign idRise  = idS & ~idPrev;
  assign idFall  = ~idS & idPrev;

  logic [LOW_W-1:0] lowCnt;
  logic [CNT_W-1:0] addrCnt, valCnt;
  logic edgesInLow, valPhase;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      clkPrev    <= 1'b1;
      idPrev     <= 1'b1;
      lowCnt     <= '0;
      addrCnt    <= '0;
      valCnt     <= '0;
      edgesInLow <= 1'b0;
      valPhase   <= 1'b0;
    end else begin
      clkPrev <= clkS;
      idPrev  <= idS;
      if (!idS) lowCnt <= (lowCnt == LOW_MAX) ? lowCnt : lowCnt + 1'b1;
      else      lowCnt <= '0;
      if (idFall) begin
        edgesInLow <= clkRise;
        addrCnt    <= clkRise ? CNT_W'(1) : '0;
      end else if (st.shiftAddr) begin
        edgesInLow <= 1'b1;
        if (addrCnt != CNT_FULL) addrCnt <= addrCnt + 1'b1;
      end
      if (st.decodeAddr) begin
        valPhase <= 1'b1;
        valCnt   <= '0;
      end else if (st.commit) begin
        valPhase <= 1'b0;
        valCnt   <= '0;
      end else if (st.shiftVal && valPhase && valCnt != CNT_FULL) begin
        valCnt <= valCnt + 1'b1;
      end
    end
  end

  always_comb begin
    st            = '0;
    st.sampleBit  = dataS;
    st.shiftAddr  = clkRise & ~idS;
    st.shiftVal   = clkRise & idS;
    st.decodeAddr = idRise & edgesInLow;
    st.addrFull   = (addrCnt == CNT_FULL);
    st.commit     = idRise & ~edgesInLow & (lowCnt >= LOW_MAX) &
                    valPhase & (valCnt == CNT_FULL);
    st.slotD1     = valPhase & idS & (valCnt == CNT_W'(BYTE_W - 2));
    st.slotD0     = valPhase & idS & (valCnt == CNT_W'(BYTE_W - 1));
  end

  // R4: a commit never coincides with a bit being shifted
  assert_commit_clockfree_R4: assert property (@(posedge clk) disable iff (!rstN)
    st.commit |-> !(st.shiftAddr || st.shiftVal));

  // R9: the two read slots never overlap
  assert_slots_exclusive_R9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({st.slotD1, st.slotD0}));

endmodule

// File: rtl/serctlDatapath.sv
module serctlDatapath
  import serctl_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  busStrobes_t st,
  input  logic [1:0]  statusInN,
  output logic        busDataPullDown,
  output logic [1:0]  srcSel,
  output logic        muteOn,
  output logic        loudOn,
  output logic [3:0]  bassStep,
  output logic [3:0]  trebleStep,
  output logic [5:0]  leftAtten,
  output logic [5:0]  rightAtten,
  output logic [1:0]  chanMode
);

  localparam logic [3:0] TONE_FLAT = 4'd6;
  localparam logic [3:0] TONE_TOP  = 4'd12;
  localparam logic [5:0] ATT_TOP   = 6'd40;

  logic [1:0] statSync [SYNC_STAGES];
  logic [BYTE_W-1:0] addrShift, valShift;
  logic addrOk;
  logic [2:0] funcSel;
  logic [1:0] statReg, selCode;
  logic loudReg;
  logic [3:0] bassReg, trebReg;
  logic [5:0] leftReg, rightReg;
  chanMode_e modeReg;

  for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_stat
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)       statSync[s] <= 2'b11;
      else if (s == 0) statSync[s] <= statusInN;
      else             statSync[s] <= statSync[(s == 0) ? 0 : s-1];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrShift <= '0;
      valShift  <= '0;
      addrOk    <= 1'b0;
      funcSel   <= '0;
      statReg   <= 2'b11;
      selCode   <= 2'b11;
      loudReg   <= 1'b0;
      bassReg   <= TONE_FLAT;
      trebReg   <= TONE_FLAT;
      leftReg   <= ATT_TOP;
      rightReg  <= ATT_TOP;
      modeReg   <= MODE_STEREO;
    end else begin
      if (st.shiftAddr) addrShift <= {addrShift[BYTE_W-2:0], st.sampleBit};
      if (st.shiftVal)  valShift  <= {valShift[BYTE_W-2:0], st.sampleBit};
      if (st.decodeAddr) begin
        addrOk  <= st.addrFull && (addrShift[7:3] == DEV_BASE);
        funcSel <= addrShift[2:0];
        if (addrShift[2:0] == FN_READ) statReg <= statSync[SYNC_STAGES-1];
      end
      if (st.commit && addrOk) begin
        unique case (funcSel)
          FN_SOURCE: selCode  <= valShift[1:0];
          FN_LOUD:   loudReg  <= valShift[0];
          FN_BASS:   bassReg  <= valShift[3:0];
          FN_TREBLE: trebReg  <= valShift[3:0];
          FN_LEFT:   leftReg  <= valShift[5:0];
          FN_RIGHT:  rightReg <= valShift[5:0];
          FN_MODE: if (valShift[2])
                     modeReg <= valShift[1] ? MODE_RIGHT :
                                (valShift[0] ? MODE_STEREO : MODE_LEFT);
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    busDataPullDown = addrOk && (funcSel == FN_READ) &&
                      ((st.slotD1 && !statReg[1]) || (st.slotD0 && !statReg[0]));
    muteOn     = (selCode == 2'b11);
    srcSel     = muteOn ? 2'b00 : selCode;
    loudOn     = loudReg;
    bassStep   = (bassReg > TONE_TOP) ? TONE_TOP : bassReg;
    trebleStep = (trebReg > TONE_TOP) ? TONE_TOP : trebReg;
    leftAtten  = (leftReg > ATT_TOP) ? ATT_TOP : leftReg;
    rightAtten = (rightReg > ATT_TOP) ? ATT_TOP : rightReg;
    chanMode   = modeReg;
  end

  // R4: settings move only on a commit strobe
  assert_hold_without_commit_R4: assert property (@(posedge clk) disable iff (!rstN)
    !st.commit |=> $stable({selCode, loudReg, bassReg, trebReg, leftReg, rightReg, modeReg}));

  // R2: the device becomes selected only through an address decode
  assert_select_by_decode_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(addrOk) |-> $past(st.decodeAddr));

  // R8: a mode code with bit 2 clear holds the mode
  assert_mode_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (st.commit && addrOk && funcSel == FN_MODE && !valShift[2]) |=> $stable(modeReg));

  // R9: the data line is pulled only inside a read slot
  assert_pull_in_slot_R9: assert property (@(posedge clk) disable iff (!rstN)
    busDataPullDown |-> (st.slotD1 || st.slotD0));

  // R9: returned status does not move while a slot is open
  assert_status_steady_R9: assert property (@(posedge clk) disable iff (!rstN)
    (st.slotD1 || st.slotD0) |-> $stable(statReg));

endmodule

// File: rtl/serialCtrlSlave.sv
module serialCtrlSlave
  import serctl_pkg::*;
#(
  parameter int MIN_ID_LOW  = 375,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       busClk,
  input  logic       busId,
  input  logic       busDataIn,
  input  logic [1:0] statusInN,
  output logic       busDataPullDown,
  output logic [1:0] srcSel,
  output logic       muteOn,
  output logic       loudOn,
  output logic [3:0] bassStep,
  output logic [3:0] trebleStep,
  output logic [5:0] leftAtten,
  output logic [5:0] rightAtten,
  output logic [1:0] chanMode
);

  busStrobes_t strobes;

  serctlControl #(.MIN_ID_LOW(MIN_ID_LOW), .SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .busClk(busClk), .busId(busId),
    .busDataIn(busDataIn), .st(strobes)
  );

  serctlDatapath #(.SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk(clk), .rstN(rstN), .st(strobes), .statusInN(statusInN),
    .busDataPullDown(busDataPullDown), .srcSel(srcSel), .muteOn(muteOn),
    .loudOn(loudOn), .bassStep(bassStep), .trebleStep(trebleStep),
    .leftAtten(leftAtten), .rightAtten(rightAtten), .chanMode(chanMode)
  );

endmodule

// File: tb/sim_serialCtrlSlave.sv
`timescale 1ns/1ps
module sim_serialCtrlSlave;

  localparam int MINL = 375;
  localparam int HALF = 12;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busClkR = 1'b1, busIdR = 1'b1, busDataR = 1'b1;
  logic [1:0] statN = 2'b11;
  logic pullDown, muteOn, loudOn;
  logic [1:0] srcSel, chanMode;
  logic [3:0] bassStep, trebleStep;
  logic [5:0] leftAtten, rightAtten;
  logic lineLevel;

  int total = 0, bad = 0;
  int eSel = 3, eLoud = 0, eBass = 6, eTreb = 6, eLeft = 40, eRight = 40, eMode = 0;
  bit pendOk = 0, pendFull = 0;
  int pendFunc = 0, pendVal = 0;

  always #4 clk = ~clk;
  assign lineLevel = busDataR & ~pullDown;

  serialCtrlSlave #(.MIN_ID_LOW(MINL)) u0 (
    .clk(clk), .rstN(rstN), .busClk(busClkR), .busId(busIdR),
    .busDataIn(lineLevel), .statusInN(statN), .busDataPullDown(pullDown),
    .srcSel(srcSel), .muteOn(muteOn), .loudOn(loudOn), .bassStep(bassStep),
    .trebleStep(trebleStep), .leftAtten(leftAtten), .rightAtten(rightAtten),
    .chanMode(chanMode)
  );

  task automatic waitCyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic checkEq(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int satTone(int c);
    return (c > 12) ? 12 : c;
  endfunction
  function automatic int satAtt(int c);
    return (c > 40) ? 40 : c;
  endfunction

  function automatic void applyCommit(int f, int v);
    case (f)
      0: eSel = v & 3;
      1: eLoud = v & 1;
      2: eBass = v & 15;
      3: eTreb = v & 15;
      4: eLeft = v & 63;
      5: eRight = v & 63;
      6: if (v[2]) eMode = v[1] ? 2 : (v[0] ? 0 : 1);
      default: ;
    endcase
  endfunction

  function automatic void pulseModel(int pulse);
    if (pulse >= MINL && pendFull) begin
      if (pendOk) applyCommit(pendFunc, pendVal);
      pendFull = 0;
    end
  endfunction

  task automatic checkAll(string ctx);
    checkEq({ctx, " R5 srcSel"}, srcSel, (eSel == 3) ? 0 : eSel);
    checkEq({ctx, " R5 muteOn"}, muteOn, (eSel == 3) ? 1 : 0);
    checkEq({ctx, " R5 loudOn"}, loudOn, eLoud);
    checkEq({ctx, " R6 bassStep"}, bassStep, satTone(eBass));
    checkEq({ctx, " R6 trebleStep"}, trebleStep, satTone(eTreb));
    checkEq({ctx, " R7 leftAtten"}, leftAtten, satAtt(eLeft));
    checkEq({ctx, " R7 rightAtten"}, rightAtten, satAtt(eRight));
    checkEq({ctx, " R8 chanMode"}, chanMode, eMode);
  endtask

  task automatic idPulse(int pulse);
    busIdR = 1'b0;
    waitCyc(pulse);
    busIdR = 1'b1;
    waitCyc(10);
    pulseModel(pulse);
  endtask

  // full transfer; flipStat changes the status pins in mid value phase
  task automatic runTxn(string ctx, int addr, int nA, int val, int nV, int pulse,
                        bit flipStat);
    bit isRead;
    logic [1:0] capStat;
    isRead = (nA >= 8) && (addr == 8'h47);
    capStat = statN;
    busIdR = 1'b0;
    busClkR = 1'b0;
    waitCyc(HALF);
    for (int i = 0; i < nA; i++) begin
      int k = nA - 1 - i;
      busClkR = 1'b0;
      busDataR = (k < 8) ? addr[k] : 1'($urandom);
      waitCyc(HALF);
      busClkR = 1'b1;
      waitCyc(HALF);
    end
    busIdR = 1'b1;
    waitCyc(HALF);
    for (int i = 0; i < nV; i++) begin
      int k = nV - 1 - i;
      int expPull;
      busClkR = 1'b0;
      busDataR = (k < 8) ? val[k] : 1'($urandom);
      if (flipStat && i == 3) statN = ~statN;
      waitCyc(HALF);
      expPull = 0;
      if (isRead && i == 6 && !capStat[1]) expPull = 1;
      if (isRead && i == 7 && !capStat[0]) expPull = 1;
      checkEq({ctx, " R9 pull slot"}, pullDown, expPull);
      busClkR = 1'b1;
      waitCyc(HALF);
    end
    busDataR = 1'b1;
    waitCyc(HALF);
    pendOk = (nA >= 8) && (addr[7:3] == 5'b01000);
    pendFunc = addr & 7;
    pendVal = val;
    pendFull = (nV >= 8);
    if (pulse > 0) idPulse(pulse);
    else waitCyc(10);
    checkAll(ctx);
  endtask

  initial begin
    int seedDummy;
    seedDummy = $urandom(32'd20240611);
    waitCyc(5);
    rstN = 1'b1;
    waitCyc(5);
    checkAll("R1 reset");

    runTxn("R6 bass saturate", 8'h42, 8, 8'h0D, 8, MINL + 5, 0);
    runTxn("R6 treble min", 8'h43, 8, 8'h00, 8, MINL + 5, 0);
    runTxn("R6 bass flat", 8'h42, 8, 8'hF6, 8, MINL + 5, 0);
    runTxn("R7 left 20", 8'h44, 8, 8'h14, 8, MINL + 5, 0);
    runTxn("R7 right saturate", 8'h45, 8, 8'hFF, 8, MINL + 5, 0);
    runTxn("R7 right 39", 8'h45, 8, 8'h27, 8, MINL + 5, 0);
    runTxn("R7 right 40", 8'h45, 8, 8'h28, 8, MINL + 5, 0);
    runTxn("R5 source 2", 8'h40, 8, 8'h02, 8, MINL + 5, 0);
    runTxn("R5 loud on", 8'h41, 8, 8'hFF, 8, MINL + 5, 0);
    runTxn("R8 mode left", 8'h46, 8, 8'h04, 8, MINL + 5, 0);
    runTxn("R8 mode hold", 8'h46, 8, 8'h03, 8, MINL + 5, 0);
    runTxn("R8 mode right", 8'h46, 8, 8'h06, 8, MINL + 5, 0);
    runTxn("R8 mode stereo", 8'h46, 8, 8'h05, 8, MINL + 5, 0);
    runTxn("R5 mute", 8'h40, 8, 8'h03, 8, MINL + 5, 0);
    runTxn("R2 foreign addr", 8'h48, 8, 8'h01, 8, MINL + 5, 0);
    runTxn("R2 high addr", 8'hC2, 8, 8'h00, 8, MINL + 5, 0);
    runTxn("R2 long addr burst", 8'h44, 13, 8'h05, 11, MINL + 5, 0);
    runTxn("R2 short addr", 8'h42, 5, 8'h01, 8, MINL + 5, 0);
    runTxn("R3 short value", 8'h43, 8, 8'h0B, 5, MINL + 5, 0);
    runTxn("R4 short pulse", 8'h43, 8, 8'h09, 8, MINL - 1, 0);
    idPulse(MINL);
    checkAll("R4 exact pulse");
    statN = 2'b01;
    runTxn("R9 read 01", 8'h47, 8, 8'hFF, 8, MINL + 5, 1);
    statN = 2'b10;
    runTxn("R9 read 10", 8'h47, 8, 8'hFF, 8, MINL + 5, 1);
    statN = 2'b00;
    runTxn("R9 read 00", 8'h47, 10, 8'hFF, 9, MINL + 5, 0);

    for (int n = 0; n < 40; n++) begin
      int addr, nA, nV, pulse, sel;
      sel = $urandom_range(0, 9);
      addr = (sel == 0) ? $urandom_range(0, 255) : (8'h40 | $urandom_range(0, 7));
      nA = (sel == 1) ? $urandom_range(3, 7) : 8 + $urandom_range(0, 3);
      nV = (sel == 2) ? $urandom_range(2, 7) : 8 + $urandom_range(0, 3);
      pulse = (sel == 3) ? MINL - 1 - $urandom_range(0, 100) : MINL + $urandom_range(0, 40);
      statN = 2'($urandom_range(0, 3));
      runTxn("R2 R3 R4 random", addr, nA, $urandom_range(0, 255), nV, pulse, 1'($urandom));
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule